// File: doc/BRIEF.md
# Remote Host Control and Access Port

This block sits between a remote host and an embedded processor core. The host reaches a single configuration byte through a command strobe and an enable strobe. With that byte it starts, stops and single-steps the core, keeps three access-timing configuration flags, acknowledges a bidirectional interrupt line, and chooses where its plain (non-command) cycles are steered: data memory, instruction memory, or the low or high byte of the program counter.

Data memory is shared with the core, so the block arbitrates between the two requesters. On a tie the core wins first and the two sides alternate after that. A side that asserts its lock keeps the grant until it releases the lock. Instruction memory and the program counter are open to the host only while the core reports idle. The memories and the program counter are small stubs inside the datapath.

Top module: `rhcp_top`

## Requirements
- R1: A configuration write happens on a clock edge where hostCmd, hostEn and hostWr are all high and localLock is low. With localLock high the write has no effect. A configuration read (hostCmd, hostEn and hostRd high) returns {irqMirror, 0, fastWr, latchRd, latchWr, start, memSel[1:0]}, with bit 7 as the MSB.
- R2: After a reset with hostEn, hostRd and hostWr low, coreRun is 0, hostRdata is 0x00, and the configuration byte reads 0x01 (memSel = 01, instruction memory).
- R3: If hostRd and hostWr are both high and hostEn is low while rstN is low, the start bit comes out of reset set, so coreRun is 1.
- R4: coreRun equals the start bit (bit 2). A write that changes the start bit shows on coreRun in the cycle after the write edge.
- R5: Writing a byte with bit 6 = 1 and bit 2 = 0 makes coreStep high for exactly the one cycle after the write edge. If bit 2 = 1 in that write, no pulse is produced. Bit 6 always reads back as 0.
- R6: A non-command access (hostEn high, hostCmd low) goes to the target given by memSel: 00 data memory, 01 instruction memory, 10 PC bits 7:0, 11 PC bits 15:8. Read data appears on hostRdata in the cycle after the read edge. Writes to the PC bytes show on pcOut.
- R7: While coreIdle is low, host writes to instruction memory or the PC bytes are ignored, and host reads of them return 0x00.
- R8: The two data-memory grants are never both high. A lone request is granted in the same cycle. When both sides request, the core wins the first tie after reset, and later ties go to the side that was not granted last.
- R9: A side granted while its lock input is high keeps the data-memory grant on every later cycle in which it requests. This holds through the cycle in which it drops the lock. Normal arbitration resumes on the cycle after that.
- R10: Writing a byte with bit 7 = 1 while irqIsOut is high gives a one-cycle irqAck pulse in the cycle after the write edge. With irqIsOut low, no pulse is produced.
- R11: A pcIncr pulse advances pcOut by one in the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| hostCmd | input | 1 | Command strobe, selects the configuration byte |
| hostEn | input | 1 | Host access enable |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostAddr | input | ADDR_W | Memory word address for host accesses |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Registered host read data |
| localLock | input | 1 | Local-side lock, blocks configuration writes |
| hostLock | input | 1 | Host data-memory lock request |
| coreIdle | input | 1 | Core reports it is idle |
| coreRun | output | 1 | Run enable to the core |
| coreStep | output | 1 | One-cycle single-step pulse to the core |
| pcIncr | input | 1 | Core advances the program counter |
| pcOut | output | 16 | Program counter value |
| coreDmReq | input | 1 | Core data-memory request |
| coreLock | input | 1 | Core data-memory lock request |
| coreGrant | output | 1 | Data-memory grant to the core |
| hostGrant | output | 1 | Data-memory grant to the host |
| irqMirror | input | 1 | Internal interrupt-control bit that bit 7 reads back |
| irqIsOut | input | 1 | Bidirectional interrupt pin is in output direction |
| irqAck | output | 1 | One-cycle pin-toggle pulse, used as an acknowledge |

## Verification
The two grants depend combinationally on the current requests and on the arbitration state. The bench therefore checks them 1 ns after it drives new inputs, before the next edge. Every other result is registered: coreRun, coreStep, irqAck, pcOut and hostRdata all change on the edge that captures the stimulus. They are sampled 1 ns after that edge. The zero cycle after a coreStep or irqAck pulse is checked at the following edge. The arbitration is driven with seeded random request and lock patterns, and a bench model predicts each cycle's grants from the previous cycles' outcomes.

// File: rtl/rhcp_pkg.sv
`timescale 1ns/1ps
package rhcp_pkg;
  localparam int PC_W = 16;

  typedef enum logic [1:0] {
    TGT_DM  = 2'b00,
    TGT_IM  = 2'b01,
    TGT_PCL = 2'b10,
    TGT_PCH = 2'b11
  } target_e;

  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_CORE = 2'd1,
    LK_HOST = 2'd2
  } lockOwner_e;

  typedef struct packed {
    logic    wrDm;
    logic    wrIm;
    logic    wrPcLo;
    logic    wrPcHi;
    logic    ldMem;
    logic    ldCfg;
    logic    ldZero;
    target_e tgt;
  } hostStrobe_t;
endpackage

// File: rtl/rhcp_ctrl.sv
`timescale 1ns/1ps
module rhcp_ctrl
  import rhcp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostCmd,
  input  logic        hostEn,
  input  logic        hostRd,
  input  logic        hostWr,
  input  logic [7:0]  hostWdata,
  input  logic        localLock,
  input  logic        hostLock,
  input  logic        coreIdle,
  input  logic        coreDmReq,
  input  logic        coreLock,
  input  logic        irqMirror,
  input  logic        irqIsOut,
  output logic        coreRun,
  output logic        coreStep,
  output logic        irqAck,
  output logic        coreGrant,
  output logic        hostGrant,
  output logic [7:0]  cfgValue,
  output hostStrobe_t strobe
);
  logic       startQ, fastWrQ, latchRdQ, latchWrQ, stepQ, ackQ, lastCoreQ;
  target_e    msQ;
  lockOwner_e ownerQ;

  logic cfgAcc, memAcc, cfgWr, hostDmReq, bootRun, isDm;

  assign cfgAcc    = hostEn && hostCmd;
  assign memAcc    = hostEn && !hostCmd;
  assign cfgWr     = cfgAcc && hostWr && !localLock;
  assign isDm      = (msQ == TGT_DM);
  assign hostDmReq = memAcc && (hostRd || hostWr) && isDm;
  assign bootRun   = hostRd && hostWr && !hostEn;

  // data-memory arbitration
  always_comb begin
    coreGrant = 1'b0;
    hostGrant = 1'b0;
    case (ownerQ)
      LK_CORE: coreGrant = coreDmReq;
      LK_HOST: hostGrant = hostDmReq;
      default: begin
        if (coreDmReq && hostDmReq) begin
          coreGrant = !lastCoreQ;
          hostGrant = lastCoreQ;
        end else begin
          coreGrant = coreDmReq;
          hostGrant = hostDmReq;
        end
      end
    endcase
  end

  // host access steering
  always_comb begin
    strobe.tgt    = msQ;
    strobe.wrDm   = memAcc && hostWr && isDm && hostGrant;
    strobe.wrIm   = memAcc && hostWr && (msQ == TGT_IM) && coreIdle;
    strobe.wrPcLo = memAcc && hostWr && (msQ == TGT_PCL) && coreIdle;
    strobe.wrPcHi = memAcc && hostWr && (msQ == TGT_PCH) && coreIdle;
    strobe.ldMem  = memAcc && hostRd && (isDm ? hostGrant : coreIdle);
    strobe.ldZero = memAcc && hostRd && !isDm && !coreIdle;
    strobe.ldCfg  = cfgAcc && hostRd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ    <= bootRun;
      msQ       <= TGT_IM;
      fastWrQ   <= 1'b0;
      latchRdQ  <= 1'b0;
      latchWrQ  <= 1'b0;
      stepQ     <= 1'b0;
      ackQ      <= 1'b0;
      ownerQ    <= LK_NONE;
      lastCoreQ <= 1'b0;
    end else begin
      stepQ <= cfgWr && hostWdata[6] && !hostWdata[2];
      ackQ  <= cfgWr && hostWdata[7] && irqIsOut;
      if (cfgWr) begin
        fastWrQ  <= hostWdata[5];
        latchRdQ <= hostWdata[4];
        latchWrQ <= hostWdata[3];
        startQ   <= hostWdata[2];
        msQ      <= target_e'(hostWdata[1:0]);
      end
      if (coreGrant)      lastCoreQ <= 1'b1;
      else if (hostGrant) lastCoreQ <= 1'b0;
      case (ownerQ)
        LK_CORE: if (!coreLock) ownerQ <= LK_NONE;
        LK_HOST: if (!hostLock) ownerQ <= LK_NONE;
        default: begin
          if (coreGrant && coreLock)      ownerQ <= LK_CORE;
          else if (hostGrant && hostLock) ownerQ <= LK_HOST;
        end
      endcase
    end
  end

  assign coreRun  = startQ;
  assign coreStep = stepQ;
  assign irqAck   = ackQ;
  assign cfgValue = {irqMirror, 1'b0, fastWrQ, latchRdQ, latchWrQ, startQ, msQ};

  p_grant_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({coreGrant, hostGrant}));

  p_alternate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (coreGrant && hostDmReq && ownerQ == LK_NONE && !coreLock)
    ##1 (coreDmReq && hostDmReq && ownerQ == LK_NONE) |-> hostGrant);

  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (coreGrant && coreLock && ownerQ == LK_NONE) ##1 coreDmReq |-> coreGrant);

  p_step_stopped_r5: assert property (@(posedge clk) disable iff (!rstN)
    coreStep |-> !coreRun);

  p_ack_dir_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |-> $past(irqIsOut));
endmodule

// File: rtl/rhcp_dpath.sv
`timescale 1ns/1ps
module rhcp_dpath
  import rhcp_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       strobe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWdata,
  input  logic [7:0]        cfgValue,
  input  logic              coreIdle,
  input  logic              pcIncr,
  output logic [7:0]        hostRdata,
  output logic [PC_W-1:0]   pcOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]      dmArr [DEPTH];
  logic [7:0]      imArr [DEPTH];
  logic [PC_W-1:0] pcQ;
  logic [7:0]      rdQ, memRd;

  always_comb begin
    case (strobe.tgt)
      TGT_DM:  memRd = dmArr[hostAddr];
      TGT_IM:  memRd = imArr[hostAddr];
      TGT_PCL: memRd = pcQ[7:0];
      default: memRd = pcQ[PC_W-1:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.wrDm) dmArr[hostAddr] <= hostWdata;
    if (strobe.wrIm) imArr[hostAddr] <= hostWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ <= '0;
      rdQ <= '0;
    end else begin
      if (strobe.wrPcLo)      pcQ[7:0]      <= hostWdata;
      else if (strobe.wrPcHi) pcQ[PC_W-1:8] <= hostWdata;
      else if (pcIncr)        pcQ           <= pcQ + 1'b1;
      if (strobe.ldZero)      rdQ <= 8'h00;
      else if (strobe.ldCfg)  rdQ <= cfgValue;
      else if (strobe.ldMem)  rdQ <= memRd;
    end
  end

  assign hostRdata = rdQ;
  assign pcOut     = pcQ;

  p_pc_guard_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!coreIdle && !pcIncr) |=> $stable(pcOut));

  p_busy_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldZero |=> hostRdata == 8'h00);
endmodule

// File: rtl/rhcp_top.sv
`timescale 1ns/1ps
module rhcp_top
  import rhcp_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCmd,
  input  logic              hostEn,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  input  logic              localLock,
  input  logic              hostLock,
  input  logic              coreIdle,
  output logic              coreRun,
  output logic              coreStep,
  input  logic              pcIncr,
  output logic [15:0]       pcOut,
  input  logic              coreDmReq,
  input  logic              coreLock,
  output logic              coreGrant,
  output logic              hostGrant,
  input  logic              irqMirror,
  input  logic              irqIsOut,
  output logic              irqAck
);
  hostStrobe_t strobe;
  logic [7:0]  cfgValue;

  rhcp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostCmd(hostCmd), .hostEn(hostEn),
    .hostRd(hostRd), .hostWr(hostWr), .hostWdata(hostWdata),
    .localLock(localLock), .hostLock(hostLock), .coreIdle(coreIdle),
    .coreDmReq(coreDmReq), .coreLock(coreLock), .irqMirror(irqMirror),
    .irqIsOut(irqIsOut), .coreRun(coreRun), .coreStep(coreStep),
    .irqAck(irqAck), .coreGrant(coreGrant), .hostGrant(hostGrant),
    .cfgValue(cfgValue), .strobe(strobe)
  );

  rhcp_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .cfgValue(cfgValue), .coreIdle(coreIdle),
    .pcIncr(pcIncr), .hostRdata(hostRdata), .pcOut(pcOut)
  );
endmodule

// File: tb/test_rhcp_top.sv
`timescale 1ns/1ps
module test_rhcp_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCmd = 0, hostEn = 0, hostRd = 0, hostWr = 0;
  logic [3:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic localLock = 0, hostLock = 0, coreIdle = 1, pcIncr = 0;
  logic coreRun, coreStep, coreGrant, hostGrant, irqAck;
  logic [15:0] pcOut;
  logic coreDmReq = 0, coreLock = 0, irqMirror = 0, irqIsOut = 0;

  int checks = 0;
  int errors = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  rhcp_top #(.ADDR_W(4)) i_rhcp_top (
    .clk(clk), .rstN(rstN), .hostCmd(hostCmd), .hostEn(hostEn),
    .hostRd(hostRd), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .localLock(localLock),
    .hostLock(hostLock), .coreIdle(coreIdle), .coreRun(coreRun),
    .coreStep(coreStep), .pcIncr(pcIncr), .pcOut(pcOut),
    .coreDmReq(coreDmReq), .coreLock(coreLock), .coreGrant(coreGrant),
    .hostGrant(hostGrant), .irqMirror(irqMirror), .irqIsOut(irqIsOut),
    .irqAck(irqAck)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cfgWrite(input logic [7:0] d);
    hostCmd = 1; hostEn = 1; hostWr = 1; hostWdata = d;
    tick();
    hostCmd = 0; hostEn = 0; hostWr = 0;
  endtask

  task automatic cfgRead(output logic [7:0] r);
    hostCmd = 1; hostEn = 1; hostRd = 1;
    tick();
    r = hostRdata;
    hostCmd = 0; hostEn = 0; hostRd = 0;
  endtask

  task automatic memWrite(input logic [3:0] a, input logic [7:0] d);
    hostEn = 1; hostWr = 1; hostAddr = a; hostWdata = d;
    tick();
    hostEn = 0; hostWr = 0;
  endtask

  task automatic memRead(input logic [3:0] a, output logic [7:0] r);
    hostEn = 1; hostRd = 1; hostAddr = a;
    tick();
    r = hostRdata;
    hostEn = 0; hostRd = 0;
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (3) tick();
    rstN = 1;
  endtask

  // expected {coreGrant, hostGrant} from arbitration state and requests
  function automatic logic [1:0] arbExp(input int own, input bit last, input bit cr, input bit hr);
    if (own == 1) return {cr, 1'b0};
    if (own == 2) return {1'b0, hr};
    if (cr && hr) return {!last, last};
    return {cr, hr};
  endfunction

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int own;
    bit last;
    logic [1:0] g;
    void'($urandom(32'd20240611));

    // R2 reset state
    doReset();
    chk("R2 coreRun", coreRun, 0);
    chk("R2 rdata", hostRdata, 8'h00);
    cfgRead(v);
    chk("R2 cfg reset", v, 8'h01);

    // R1 write and read back, lock blocks write, layout
    cfgWrite(8'h38);
    cfgRead(v);
    chk("R1 readback", v, 8'h38);
    localLock = 1;
    cfgWrite(8'h3B);
    localLock = 0;
    cfgRead(v);
    chk("R1 locked write ignored", v, 8'h38);
    irqMirror = 1;
    cfgRead(v);
    chk("R10 mirror bit7", v, 8'hB8);
    irqMirror = 0;

    // R4 start/stop
    cfgWrite(8'h04);
    chk("R4 run", coreRun, 1);
    cfgWrite(8'h00);
    chk("R4 stop", coreRun, 0);

    // R5 single step
    cfgWrite(8'h40);
    chk("R5 step pulse", coreStep, 1);
    tick();
    chk("R5 step single", coreStep, 0);
    cfgRead(v);
    chk("R5 step reads 0", v, 8'h00);
    cfgWrite(8'h44);
    chk("R5 no step when running", coreStep, 0);
    chk("R4 run via step write", coreRun, 1);
    cfgWrite(8'h00);

    // R10 interrupt acknowledge
    irqIsOut = 1;
    cfgWrite(8'h80);
    chk("R10 ack pulse", irqAck, 1);
    tick();
    chk("R10 ack single", irqAck, 0);
    irqIsOut = 0;
    cfgWrite(8'h80);
    chk("R10 no ack input dir", irqAck, 0);

    // R6 target steering
    coreIdle = 1;
    cfgWrite(8'h01);
    memWrite(4'd3, 8'hA5);
    memRead(4'd3, v);
    chk("R6 im read", v, 8'hA5);
    cfgWrite(8'h02);
    memWrite(4'd0, 8'h34);
    cfgWrite(8'h03);
    memWrite(4'd0, 8'h12);
    chk("R6 pc write", pcOut, 16'h1234);
    memRead(4'd0, v);
    chk("R6 pc high read", v, 8'h12);
    cfgWrite(8'h02);
    memRead(4'd0, v);
    chk("R6 pc low read", v, 8'h34);
    cfgWrite(8'h00);
    memWrite(4'd5, 8'h5A);
    memRead(4'd5, v);
    chk("R6 dm read", v, 8'h5A);

    // R11 pc increment
    pcIncr = 1;
    tick();
    pcIncr = 0;
    chk("R11 pc incr", pcOut, 16'h1235);

    // R7 busy core blocks im/pc
    cfgWrite(8'h01);
    coreIdle = 0;
    memWrite(4'd3, 8'hFF);
    memRead(4'd3, v);
    chk("R7 busy read zero", v, 8'h00);
    cfgWrite(8'h02);
    memWrite(4'd0, 8'h99);
    chk("R7 busy pc write ignored", pcOut, 16'h1235);
    coreIdle = 1;
    cfgWrite(8'h01);
    memRead(4'd3, v);
    chk("R7 im write ignored", v, 8'hA5);

    // R8 directed ties from reset
    doReset();
    cfgWrite(8'h00);
    hostEn = 1; hostRd = 1; hostAddr = 0; coreDmReq = 1;
    #1;
    chk("R8 first tie core", {coreGrant, hostGrant}, 2'b10);
    tick();
    chk("R8 second tie host", {coreGrant, hostGrant}, 2'b01);
    tick();
    chk("R8 third tie core", {coreGrant, hostGrant}, 2'b10);
    tick();
    // R9 core lock hold: last grant was core, so host wins here
    chk("R9 pre-lock host", {coreGrant, hostGrant}, 2'b01);
    tick();
    coreLock = 1;
    #1;
    chk("R9 core takes lock", {coreGrant, hostGrant}, 2'b10);
    tick();
    chk("R9 held 1", {coreGrant, hostGrant}, 2'b10);
    tick();
    chk("R9 held 2", {coreGrant, hostGrant}, 2'b10);
    coreLock = 0;
    #1;
    chk("R9 held on release", {coreGrant, hostGrant}, 2'b10);
    tick();
    chk("R9 resumes host", {coreGrant, hostGrant}, 2'b01);
    hostEn = 0; hostRd = 0; coreDmReq = 0;
    tick();

    // R3 boot running
    hostRd = 1; hostWr = 1; hostEn = 0;
    rstN = 0;
    repeat (3) tick();
    rstN = 1;
    hostRd = 0; hostWr = 0;
    chk("R3 boot run", coreRun, 1);
    cfgRead(v);
    chk("R3 start bit", v, 8'h05);

    // R8 R9 random arbitration against model
    doReset();
    cfgWrite(8'h00);
    own = 0; last = 0;
    for (int i = 0; i < 400; i++) begin
      coreDmReq = 1'($urandom % 2);
      hostEn    = 1'($urandom % 2);
      hostRd    = 1;
      coreLock  = ($urandom % 6) == 0;
      hostLock  = ($urandom % 6) == 0;
      #1;
      g = arbExp(own, last, coreDmReq, hostEn);
      chk("R8 R9 random grants", {coreGrant, hostGrant}, g);
      if (g[1]) last = 1; else if (g[0]) last = 0;
      if (own == 1) begin if (!coreLock) own = 0; end
      else if (own == 2) begin if (!hostLock) own = 0; end
      else if (g[1] && coreLock) own = 1;
      else if (g[0] && hostLock) own = 2;
      tick();
    end
    hostEn = 0; hostRd = 0; coreDmReq = 0; coreLock = 0; hostLock = 0;
    tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule